// File: doc/BRIEF.md
# Staggered DDR Refresh Sequencer

This block sits beside the command scheduler of a DDR SDRAM controller and owns periodic refresh. A periodic interval tick adds one owed refresh to a saturating credit counter. When credit is owed and the scheduler reports idle, or at once when the credit reaches its programmed ceiling, the block takes the command bus. It closes every open row with precharge-all commands spread over the chip-select groups, one group per cycle. It then issues auto-refresh commands spread the same way, so that the refresh current of all devices does not land in one cycle.

Chip selects are arranged as groups of two: group g holds chip selects 2g and 2g+1. The full stagger always runs over every group, whether or not any chip select in it is populated. After the last refresh command the block keeps its busy output high for a programmable recovery count before the scheduler may issue anything again.

A self-refresh request uses the same staggered precharge. It is followed by one refresh command driven to every enabled chip select in the same cycle, and clock enable then falls and stays low until the request is withdrawn.

Top module: `ddr_ref_seq`

## Requirements
- R1: Out of reset and whenever no command is issued, all cs_n, ras_n, cas_n and we_n are high, cke is high and busy is low. A chip select whose cs_enable bit is 0 never has cs_n low.
- R2: Each cycle with ref_tick high adds one owed refresh, up to posted_max. While the scheduler is idle (sched_idle high), one owed refresh makes busy rise two cycles after the tick cycle.
- R3: While sched_idle is low, no refresh starts until the owed count equals posted_max. Then a refresh starts regardless of sched_idle, with busy rising two cycles after the tick that reached the maximum.
- R4: A refresh sequence begins with precharge-all (ras_n=0, cas_n=1, we_n=0) on three consecutive cycles for groups 0, 1 and 2 in that order. In the cycle for group g, cs_n[i] is low exactly for enabled chip selects i in {2g, 2g+1}.
- R5: Immediately after the third precharge come three consecutive auto-refresh cycles (ras_n=0, cas_n=0, we_n=1) for groups 0, 1 and 2, with the same chip-select pattern as R4.
- R6: The six command cycles are spent even for groups with no enabled chip select. In those cycles ras_n, cas_n and we_n carry the command while every cs_n stays high.
- R7: busy is high from the first precharge cycle through the last refresh cycle. It then stays high for max(refrec,1)-1 further cycles, so the first free cycle is refrec cycles after the last refresh cycle (one cycle if refrec is 0 or 1).
- R8: Each refresh sequence consumes one owed refresh. Owed refreshes accumulated while the scheduler was busy are serviced one sequence each once it is idle. Exactly as many sequences run as ticks were owed, with one free cycle between sequences.
- R9: sr_req high while no sequence runs makes busy rise on the next cycle. Three precharge-all cycles as in R4 follow, then one refresh cycle with cs_n low on every enabled chip select at once.
- R10: cke goes low on the cycle after the self-refresh command and stays low, with all cs_n high, while sr_req stays high. The cycle after sr_req is seen low, cke is high and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per refresh interval |
| posted_max | input | CNT_W | Ceiling of owed refreshes; reaching it forces a refresh (at least 1) |
| refrec | input | REC_W | Refresh-to-activate gap in clocks, counted from the last refresh command |
| cs_enable | input | NUM_GROUPS*CS_PER_GRP | Populated chip selects |
| sched_idle | input | 1 | Scheduler has no access in flight and allows a refresh |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| cs_n | output | NUM_GROUPS*CS_PER_GRP | Per-chip-select select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the devices |
| busy | output | 1 | Command bus owned by the refresh block; scheduler must hold off |

## Verification
The checker assumes that the scheduler drives no bus command of its own, that posted_max is at least 1, and that refrec and cs_enable are changed only while busy is low. The stimulus picks chip-select masks, recovery counts, ceilings and tick counts from a seeded $urandom. Configuration is changed only between sequences with busy low, and no tick is sent while a self-refresh request is held. A self-refresh request is raised only when no refresh credit is owed, so the credit path and the self-refresh path are checked one at a time.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_REF,
    ST_REC,
    ST_SRREF,
    ST_SRHOLD
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF
  } cmd_e;
endpackage

// File: rtl/ref_credit.sv
module ref_credit #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             consume,
  input  logic [CNT_W-1:0] max_cnt,
  output logic             credit_nz,
  output logic             credit_full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (tick && !consume && (cnt_q < max_cnt)) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end else if (!tick && consume && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign credit_nz   = (cnt_q != '0);
  assign credit_full = (cnt_q >= max_cnt);
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import ddr_ref_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int REC_W      = 6,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             credit_nz,
  input  logic             credit_full,
  input  logic             sched_idle,
  input  logic             sr_req,
  input  logic [REC_W-1:0] refrec,
  output logic             consume,
  output logic             busy,
  output cmd_e             cmd,
  output logic [GRP_W-1:0] grp,
  output logic             all_grp,
  output logic             cke
);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

  seq_state_e       st_q, st_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             sr_q, sr_d;

  always_comb begin
    st_d    = st_q;
    grp_d   = grp_q;
    rec_d   = rec_q;
    sr_d    = sr_q;
    consume = 1'b0;
    case (st_q)
      ST_IDLE: begin
        grp_d = '0;
        if (sr_req) begin
          st_d = ST_PRE;
          sr_d = 1'b1;
        end else if (credit_nz && (sched_idle || credit_full)) begin
          st_d    = ST_PRE;
          sr_d    = 1'b0;
          consume = 1'b1;
        end
      end
      ST_PRE: begin
        if (grp_q == LAST_GRP) begin
          grp_d = '0;
          st_d  = sr_q ? ST_SRREF : ST_REF;
        end else begin
          grp_d = grp_q + GRP_W'(1);
        end
      end
      ST_REF: begin
        if (grp_q == LAST_GRP) begin
          grp_d = '0;
          if (refrec <= REC_W'(1)) begin
            st_d = ST_IDLE;
          end else begin
            st_d  = ST_REC;
            rec_d = refrec - REC_W'(2);
          end
        end else begin
          grp_d = grp_q + GRP_W'(1);
        end
      end
      ST_REC: begin
        if (rec_q == '0) st_d = ST_IDLE;
        else             rec_d = rec_q - REC_W'(1);
      end
      ST_SRREF:  st_d = ST_SRHOLD;
      ST_SRHOLD: if (!sr_req) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      grp_q <= '0;
      rec_q <= '0;
      sr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      grp_q <= grp_d;
      rec_q <= rec_d;
      sr_q  <= sr_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_PRE:             cmd = CMD_PRE;
      ST_REF, ST_SRREF:   cmd = CMD_REF;
      default:            cmd = CMD_NOP;
    endcase
  end

  assign busy    = (st_q != ST_IDLE);
  assign grp     = grp_q;
  assign all_grp = (st_q == ST_SRREF);
  assign cke     = (st_q != ST_SRHOLD);
endmodule

// File: rtl/ref_cmd_decode.sv
module ref_cmd_decode
  import ddr_ref_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int CS_PER_GRP = 2,
  localparam int NUM_CS    = NUM_GROUPS * CS_PER_GRP,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  cmd_e              cmd,
  input  logic [GRP_W-1:0]  grp,
  input  logic              all_grp,
  input  logic [NUM_CS-1:0] cs_enable,
  output logic [NUM_CS-1:0] cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);
  logic active;
  assign active = (cmd != CMD_NOP);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    localparam int GI = i / CS_PER_GRP;
    logic member;
    assign member  = all_grp || (grp == GRP_W'(GI));
    assign cs_n[i] = !(active && member && cs_enable[i]);
  end

  always_comb begin
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    case (cmd)
      CMD_PRE: begin ras_n = 1'b0; we_n  = 1'b0; end
      CMD_REF: begin ras_n = 1'b0; cas_n = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_ref_seq.sv
module ddr_ref_seq
  import ddr_ref_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int CS_PER_GRP = 2,
  parameter int CNT_W      = 4,
  parameter int REC_W      = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ref_tick,
  input  logic [CNT_W-1:0]                 posted_max,
  input  logic [REC_W-1:0]                 refrec,
  input  logic [NUM_GROUPS*CS_PER_GRP-1:0] cs_enable,
  input  logic                             sched_idle,
  input  logic                             sr_req,
  output logic [NUM_GROUPS*CS_PER_GRP-1:0] cs_n,
  output logic                             ras_n,
  output logic                             cas_n,
  output logic                             we_n,
  output logic                             cke,
  output logic                             busy
);
  localparam int NUM_CS = NUM_GROUPS * CS_PER_GRP;
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic             credit_nz, credit_full, consume, all_grp;
  cmd_e             cmd;
  logic [GRP_W-1:0] grp;

  ref_credit #(.CNT_W(CNT_W)) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (ref_tick),
    .consume     (consume),
    .max_cnt     (posted_max),
    .credit_nz   (credit_nz),
    .credit_full (credit_full)
  );

  ref_seq_fsm #(.NUM_GROUPS(NUM_GROUPS), .REC_W(REC_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .credit_nz   (credit_nz),
    .credit_full (credit_full),
    .sched_idle  (sched_idle),
    .sr_req      (sr_req),
    .refrec      (refrec),
    .consume     (consume),
    .busy        (busy),
    .cmd         (cmd),
    .grp         (grp),
    .all_grp     (all_grp),
    .cke         (cke)
  );

  ref_cmd_decode #(.NUM_GROUPS(NUM_GROUPS), .CS_PER_GRP(CS_PER_GRP)) u_dec (
    .cmd       (cmd),
    .grp       (grp),
    .all_grp   (all_grp),
    .cs_enable (cs_enable),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n)
  );
endmodule

// File: rtl/ddr_ref_seq_chk.sv
module ddr_ref_seq_chk #(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic [NUM_CS-1:0] cs_enable,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cke,
  input logic              busy
);
  // R1
  mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_n) & (~cs_enable)) == '0);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n && ras_n && cas_n && we_n));

  // R7
  start_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!ras_n && cas_n && !we_n));

  // R4
  pre_stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n && !we_n) |-> ($countones(~cs_n) <= 2));

  // R10
  cke_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (&cs_n && busy));

  // R10
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(!ras_n && !cas_n && we_n));
endmodule

bind ddr_ref_seq ddr_ref_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .cs_enable (cs_enable),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .cke       (cke),
  .busy      (busy)
);

// File: tb/ddr_ref_seq_tb.sv
`timescale 1ns/1ps
module ddr_ref_seq_tb;
  logic       clk, rst_n, ref_tick, sched_idle, sr_req;
  logic [3:0] posted_max;
  logic [5:0] refrec;
  logic [5:0] cs_enable, cs_n;
  logic       ras_n, cas_n, we_n, cke, busy;

  int tests, fails;

  ddr_ref_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .posted_max(posted_max),
    .refrec(refrec), .cs_enable(cs_enable), .sched_idle(sched_idle),
    .sr_req(sr_req), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_cs(input int g, input logic [5:0] en);
    logic [5:0] m;
    m = 6'b000011 << (2 * g);
    return ~(m & en);
  endfunction

  function automatic int exp_tail(input int rr);
    return (rr <= 1) ? 0 : rr - 1;
  endfunction

  // Called at the first negedge with busy high; returns at the first free negedge.
  task automatic watch_seq(input logic [5:0] en, input int rr, input bit sr);
    int n;
    for (int g = 0; g < 3; g++) begin
      chk(!ras_n && cas_n && !we_n, "R4", "precharge code", {ras_n, cas_n, we_n}, 3'b010);
      chk(cs_n == exp_cs(g, en), (en[2*g+:2] == 2'b00) ? "R6" : "R4",
          "precharge cs_n", cs_n, exp_cs(g, en));
      @(negedge clk);
    end
    if (sr) return;
    for (int g = 0; g < 3; g++) begin
      chk(!ras_n && !cas_n && we_n, "R5", "refresh code", {ras_n, cas_n, we_n}, 3'b001);
      chk(cs_n == exp_cs(g, en), (en[2*g+:2] == 2'b00) ? "R6" : "R5",
          "refresh cs_n", cs_n, exp_cs(g, en));
      chk(busy, "R7", "busy in refresh", busy, 1);
      @(negedge clk);
    end
    n = 0;
    while (busy && n < 80) begin
      chk(&cs_n && ras_n, "R7", "quiet in recovery", {cs_n, ras_n}, 7'h7f);
      n++;
      @(negedge clk);
    end
    chk(n == exp_tail(rr), "R7", "recovery length", n, exp_tail(rr));
  endtask

  task automatic pulse_tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // Count sequences until no busy is seen for several cycles.
  task automatic drain(input logic [5:0] en, input int rr, output int cnt);
    int w;
    cnt = 0;
    forever begin
      w = 0;
      while (!busy && w < 6) begin @(negedge clk); w++; end
      if (!busy) break;
      watch_seq(en, rr, 1'b0);
      cnt++;
    end
  endtask

  initial begin
    int cnt, k, mx, rr;
    logic [5:0] en;
    void'($urandom(32'h5eed_0042));
    tests = 0; fails = 0;
    rst_n = 1'b0; ref_tick = 1'b0; sched_idle = 1'b0; sr_req = 1'b0;
    posted_max = 4'd4; refrec = 6'd5; cs_enable = 6'h3f;
    repeat (3) @(negedge clk);
    chk(&cs_n && ras_n && cas_n && we_n, "R1", "reset bus", {cs_n, ras_n, cas_n, we_n}, 9'h1ff);
    chk(cke && !busy, "R1", "reset cke/busy", {cke, busy}, 2'b10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && &cs_n, "R1", "idle after reset", {busy, cs_n}, 7'h3f);

    // R2: idle scheduler, single tick
    sched_idle = 1'b1; cs_enable = 6'h3f; refrec = 6'd10;
    pulse_tick();
    chk(!busy, "R2", "busy one cycle after tick", busy, 0);
    @(negedge clk);
    chk(busy, "R2", "busy two cycles after tick", busy, 1);
    watch_seq(6'h3f, 10, 1'b0);
    repeat (5) @(negedge clk);
    chk(!busy, "R8", "no extra sequence", busy, 0);

    // R3: forced refresh at ceiling, then R8 drain of remaining credit
    sched_idle = 1'b0;
    mx = 2 + int'($urandom_range(3));
    posted_max = 4'(mx);
    en = 6'($urandom); cs_enable = en; rr = int'($urandom_range(20)); refrec = 6'(rr);
    for (int i = 0; i < mx - 1; i++) begin
      pulse_tick();
      repeat (3) @(negedge clk);
      chk(!busy, "R3", "held off below ceiling", busy, 0);
    end
    repeat (10) @(negedge clk);
    chk(!busy, "R3", "held off while busy scheduler", busy, 0);
    pulse_tick();
    @(negedge clk);
    chk(busy, "R3", "forced start at ceiling", busy, 1);
    watch_seq(en, rr, 1'b0);
    sched_idle = 1'b1;
    drain(en, rr, cnt);
    chk(cnt == mx - 1, "R8", "remaining credit serviced", cnt, mx - 1);

    // R8: random accumulate then drain
    posted_max = 4'd12;
    for (int it = 0; it < 15; it++) begin
      sched_idle = 1'b0;
      en = 6'($urandom); cs_enable = en;
      rr = int'($urandom_range(25)); refrec = 6'(rr);
      k = 1 + int'($urandom_range(10));
      for (int i = 0; i < k; i++) begin
        pulse_tick();
        repeat (int'($urandom_range(3))) @(negedge clk);
      end
      chk(!busy, "R2", "no start while scheduler busy", busy, 0);
      sched_idle = 1'b1;
      drain(en, rr, cnt);
      chk(cnt == k, "R8", "sequences per owed tick", cnt, k);
    end

    // R2: saturation at ceiling while idle (forced runs, so only ceiling matters)
    sched_idle = 1'b0; posted_max = 4'd3; en = 6'h3f; cs_enable = en; refrec = 6'd1;
    // two ticks stay below ceiling, third forces
    pulse_tick(); pulse_tick();
    pulse_tick();
    @(negedge clk);
    chk(busy, "R3", "third tick forces", busy, 1);
    watch_seq(en, 1, 1'b0);
    sched_idle = 1'b1;
    drain(en, 1, cnt);
    chk(cnt == 2, "R2", "credit after saturation", cnt, 2);

    // R6: sparse populations
    en = 6'b000011; cs_enable = en; refrec = 6'd0;
    pulse_tick(); @(negedge clk);
    chk(busy, "R6", "start with one group", busy, 1);
    watch_seq(en, 0, 1'b0);
    en = 6'b000000; cs_enable = en; refrec = 6'd2;
    pulse_tick(); @(negedge clk);
    chk(busy, "R6", "start with no chip select", busy, 1);
    watch_seq(en, 2, 1'b0);

    // R9 / R10: self-refresh entry and exit
    repeat (4) @(negedge clk);
    en = 6'b110110; cs_enable = en;
    sr_req = 1'b1;
    @(negedge clk);
    chk(busy, "R9", "busy after request", busy, 1);
    watch_seq(en, 0, 1'b1);
    chk(!ras_n && !cas_n && we_n, "R9", "self refresh code", {ras_n, cas_n, we_n}, 3'b001);
    chk(cs_n == ~en, "R9", "all enabled at once", cs_n, ~en);
    chk(cke, "R10", "cke high on command", cke, 1);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk(!cke && &cs_n && busy, "R10", "held in self refresh", {cke, cs_n, busy}, 8'h7f);
      @(negedge clk);
    end
    sr_req = 1'b0;
    @(negedge clk);
    chk(cke && !busy, "R10", "exit", {cke, busy}, 2'b10);
    repeat (4) @(negedge clk);
    chk(!busy && &cs_n, "R1", "quiet after exit", {busy, cs_n}, 7'h3f);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule